// File: doc/BRIEF.md
# Dual-Plane Pixel Colour Formatter

This block turns a stream of scanline pixels into display words. Each pixel arrives as three values taken together: an 8-bit colour index, a 32-bit direct-colour word and a 32-bit control word. The control word decides, pixel by pixel, whether the colour comes from a 256-entry red/green/blue palette or straight from the direct-colour word. The chosen colour is then packed into one of four output depths, picked by a static configuration input.

The palette write port is brought out so that a separate register block can load colours. Pixels move through a two-stage pipeline with a valid/ready handshake on both sides. The first stage reads the palette and decodes the control word. The second stage selects the colour and packs it. A stall at the output holds both stages in place.

Top module: `pixel_colour_fmt`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: After reset, palette entry 255 holds white (red, green and blue all 8'hFF) and every other entry holds black.
- R3: When `cfg_fmt` is 3 and the low byte of `in_ctrl` is 8'h03, the pixel is direct colour: `out_pixel` = {8'h00, in_direct[15:8], in_direct[23:16], in_direct[31:24]}. This is the byte-reversed word with its top byte cleared.
- R4: Any other value in the low byte of `in_ctrl` selects the palette entry addressed by `in_index`. Bits 31:8 of `in_ctrl` have no effect.
- R5: With `cfg_fmt` = 0 (8-bit), `out_pixel` = {24'h0, red[7:5], green[7:5], blue[7:6]}.
- R6: With `cfg_fmt` = 1 (15-bit), `out_pixel` = {17'h0, red[7:3], green[7:3], blue[7:3]}.
- R7: With `cfg_fmt` = 2 (16-bit), `out_pixel` = {16'h0, red[7:3], green[7:2], blue[7:3]}.
- R8: With `cfg_fmt` = 3 (32-bit), a palette pixel gives `out_pixel` = {8'h00, red, green, blue}.
- R9: With `cfg_fmt` other than 3, a control byte of 8'h03 still selects the palette.
- R10: A pixel accepted at a clock edge (`in_valid` and `in_ready` both high) shows on `out_valid` two edges later, provided the output is not stalled in between.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_pixel` hold. `in_ready` is low. No pixel is lost, duplicated or reordered.
- R12: A palette write (`pal_we` high at an edge, data {red, green, blue} on `pal_data`) is seen by pixels accepted at later edges. A pixel accepted at the same edge as the write sees the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fmt | input | 2 | Output depth: 0 = 8-bit, 1 = 15-bit, 2 = 16-bit, 3 = 32-bit |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can take an input pixel |
| in_index | input | 8 | Indexed-plane colour index |
| in_direct | input | 32 | Direct-colour plane word |
| in_ctrl | input | 32 | Control plane word |
| pal_we | input | 1 | Palette write enable |
| pal_addr | input | 8 | Palette write entry |
| pal_data | input | 24 | Palette write colour {red, green, blue} |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Sink can take the output pixel |
| out_pixel | output | 32 | Packed output pixel |

## Verification
The assertions check the handshake on every cycle. They cover the reset state, the two-edge latency of an accepted pixel, the hold of `out_pixel` and the drop of `in_ready` while the output is stalled, and the zero upper bits each depth leaves in `out_pixel`. The bench's scenarios are needed for the colour values themselves. They sweep every palette entry through all four depths, use byte-reversed direct words, and show that the 8'h03 code is ignored outside 32-bit mode. They also cover the reset palette contents, the write-versus-accept ordering at one edge, and the lossless ordering of pixels under an irregular `out_ready` pattern.

// File: rtl/pcf_pkg.sv
package pcf_pkg;
    typedef enum logic [1:0] {
        FMT_8  = 2'd0,
        FMT_15 = 2'd1,
        FMT_16 = 2'd2,
        FMT_32 = 2'd3
    } fmt_e;

    typedef struct packed {
        logic [7:0] red;
        logic [7:0] green;
        logic [7:0] blue;
    } rgb_t;

    localparam int PIX_W = 32;
endpackage

// File: rtl/pcf_palette.sv
module pcf_palette
    import pcf_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  rgb_t             wdata,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] raddr,
    output rgb_t             rdata
);
    localparam int ENTRIES = 1 << IDX_W;

    rgb_t table_q [ENTRIES];

    // Entries reset to black, last one to white; write lands at the edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                table_q[i] <= (i == ENTRIES - 1) ? 24'hFFFFFF : 24'h000000;
            end
        end else if (we) begin
            table_q[waddr] <= wdata;
        end
    end

    // Registered read: old contents are seen when read and write share an edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= table_q[raddr];
        end
    end
endmodule

// File: rtl/pcf_decode.sv
module pcf_decode
    import pcf_pkg::*;
#(
    parameter logic [7:0] DIRECT_CODE = 8'h03
) (
    input  fmt_e        fmt,
    input  logic [31:0] ctrl_word,
    input  logic [31:0] direct_word,
    output logic        use_direct,
    output rgb_t        direct_rgb
);
    logic [31:0] ctrl_sw;
    logic [31:0] direct_sw;

    always_comb begin
        ctrl_sw   = {ctrl_word[7:0], ctrl_word[15:8], ctrl_word[23:16], ctrl_word[31:24]};
        direct_sw = {direct_word[7:0], direct_word[15:8], direct_word[23:16], direct_word[31:24]};
        use_direct = (fmt == FMT_32) && (ctrl_sw[31:24] == DIRECT_CODE);
        direct_rgb = direct_sw[23:0];
    end
endmodule

// File: rtl/pcf_pack.sv
module pcf_pack
    import pcf_pkg::*;
(
    input  fmt_e             fmt,
    input  rgb_t             colour,
    output logic [PIX_W-1:0] pixel
);
    always_comb begin
        pixel = '0;
        unique case (fmt)
            FMT_8:  pixel[7:0]  = {colour.red[7:5], colour.green[7:5], colour.blue[7:6]};
            FMT_15: pixel[14:0] = {colour.red[7:3], colour.green[7:3], colour.blue[7:3]};
            FMT_16: pixel[15:0] = {colour.red[7:3], colour.green[7:2], colour.blue[7:3]};
            FMT_32: pixel[23:0] = {colour.red, colour.green, colour.blue};
            default: pixel = '0;
        endcase
    end
endmodule

// File: rtl/pixel_colour_fmt.sv
module pixel_colour_fmt
    import pcf_pkg::*;
#(
    parameter int         IDX_W       = 8,
    parameter logic [7:0] DIRECT_CODE = 8'h03
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_fmt,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IDX_W-1:0] in_index,
    input  logic [31:0]      in_direct,
    input  logic [31:0]      in_ctrl,
    input  logic             pal_we,
    input  logic [IDX_W-1:0] pal_addr,
    input  logic [23:0]      pal_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [31:0]      out_pixel
);
    fmt_e fmt;
    logic advance;
    logic take;

    logic dec_direct;
    rgb_t dec_rgb;
    rgb_t pal_rgb;

    logic s1_valid_q;
    logic s1_direct_q;
    rgb_t s1_rgb_q;
    rgb_t sel_rgb;
    logic [PIX_W-1:0] packed_pix;

    logic             s2_valid_q;
    logic [PIX_W-1:0] s2_pixel_q;

    assign fmt     = fmt_e'(cfg_fmt);
    assign advance = !s2_valid_q || out_ready;
    assign take    = advance && in_valid;

    pcf_palette #(.IDX_W(IDX_W)) u_palette (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pal_we),
        .waddr (pal_addr),
        .wdata (rgb_t'(pal_data)),
        .rd_en (take),
        .raddr (in_index),
        .rdata (pal_rgb)
    );

    pcf_decode #(.DIRECT_CODE(DIRECT_CODE)) u_decode (
        .fmt         (fmt),
        .ctrl_word   (in_ctrl),
        .direct_word (in_direct),
        .use_direct  (dec_direct),
        .direct_rgb  (dec_rgb)
    );

    // Stage 1: palette read plus decoded control and direct colour.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid_q  <= 1'b0;
            s1_direct_q <= 1'b0;
            s1_rgb_q    <= '0;
        end else if (advance) begin
            s1_valid_q <= in_valid;
            if (in_valid) begin
                s1_direct_q <= dec_direct;
                s1_rgb_q    <= dec_rgb;
            end
        end
    end

    assign sel_rgb = s1_direct_q ? s1_rgb_q : pal_rgb;

    pcf_pack u_pack (
        .fmt    (fmt),
        .colour (sel_rgb),
        .pixel  (packed_pix)
    );

    // Stage 2: packed output register, held while the sink stalls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid_q <= 1'b0;
            s2_pixel_q <= '0;
        end else if (advance) begin
            s2_valid_q <= s1_valid_q;
            if (s1_valid_q) begin
                s2_pixel_q <= packed_pix;
            end
        end
    end

    assign in_ready  = advance;
    assign out_valid = s2_valid_q;
    assign out_pixel = s2_pixel_q;
endmodule

// File: rtl/pcf_checker.sv
module pcf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  cfg_fmt,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_pixel
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!out_valid && in_ready));

    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid && in_ready) && in_ready) |=> out_valid);

    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel)));

    assert_stall_backpressure_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    assert_width8_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_fmt == 2'd0) |-> (out_pixel[31:8] == 24'h0));

    assert_width15_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_fmt == 2'd1) |-> (out_pixel[31:15] == 17'h0));

    assert_width16_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_fmt == 2'd2) |-> (out_pixel[31:16] == 16'h0));

    assert_topbyte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_pixel[31:24] == 8'h0));
endmodule

bind pixel_colour_fmt pcf_checker u_pcf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_fmt   (cfg_fmt),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pixel (out_pixel)
);

// File: tb/pixel_colour_fmt_bench.sv
module pixel_colour_fmt_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_fmt = 2'd3;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_index = '0;
    logic [31:0] in_direct = '0;
    logic [31:0] in_ctrl = '0;
    logic        pal_we = 1'b0;
    logic [7:0]  pal_addr = '0;
    logic [23:0] pal_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_pixel;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit lat_on = 1'b0;
    bit stall_pend = 1'b0;
    logic [31:0] stall_pix = '0;

    logic [23:0] model [256];
    logic [31:0] exp_q [$];
    int          acc_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    pixel_colour_fmt u_pixel_colour_fmt (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_index(in_index), .in_direct(in_direct), .in_ctrl(in_ctrl),
        .pal_we(pal_we), .pal_addr(pal_addr), .pal_data(pal_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_pix(input logic [1:0] f, input logic [7:0] idx,
                                               input logic [31:0] dw, input logic [31:0] cw);
        logic [7:0] r, g, b;
        if (f == 2'd3 && cw[7:0] == 8'h03) begin
            r = dw[15:8]; g = dw[23:16]; b = dw[31:24];
        end else begin
            {r, g, b} = model[idx];
        end
        case (f)
            2'd0: return {24'h0, r[7:5], g[7:5], b[7:6]};
            2'd1: return {17'h0, r[7:3], g[7:3], b[7:3]};
            2'd2: return {16'h0, r[7:3], g[7:2], b[7:3]};
            default: return {8'h0, r, g, b};
        endcase
    endfunction

    task automatic cycle(input logic iv, input logic [7:0] ix, input logic [31:0] dw,
                         input logic [31:0] cw, input logic ordy, input logic we,
                         input logic [7:0] wa, input logic [23:0] wd, input string tag);
        logic [31:0] e;
        int a;
        string t;
        @(negedge clk);
        in_valid = iv; in_index = ix; in_direct = dw; in_ctrl = cw;
        out_ready = ordy; pal_we = we; pal_addr = wa; pal_data = wd;
        #1;
        if (stall_pend) begin
            check(out_valid && out_pixel == stall_pix, "R11 hold", out_pixel, stall_pix);
        end
        stall_pend = out_valid && !out_ready;
        stall_pix  = out_pixel;
        if (in_valid && in_ready) begin
            exp_q.push_back(expect_pix(cfg_fmt, ix, dw, cw));
            acc_q.push_back(cyc);
            tag_q.push_back(tag);
        end
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 duplicate", out_pixel, 32'h0);
            end else begin
                e = exp_q.pop_front();
                a = acc_q.pop_front();
                t = tag_q.pop_front();
                check(out_pixel == e, t, out_pixel, e);
                if (lat_on) check(cyc - a == 2, "R10 latency", cyc - a, 2);
            end
        end
        if (we) model[wa] = wd;
        cyc++;
    endtask

    task automatic drain();
        for (int i = 0; i < 8; i++) cycle(1'b0, 8'h0, 32'h0, 32'h0, 1'b1, 1'b0, 8'h0, 24'h0, "");
        check(exp_q.size() == 0, "R11 loss", exp_q.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) model[i] = (i == 255) ? 24'hFFFFFF : 24'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!out_valid, "R1 out_valid", out_valid, 0);
        check(in_ready, "R1 in_ready", in_ready, 1);

        // R2: reset palette contents read in 32-bit depth.
        cfg_fmt = 2'd3;
        lat_on = 1'b1;
        for (int i = 0; i < 256; i++)
            cycle(1'b1, i[7:0], 32'h0, 32'h0, 1'b1, 1'b0, 8'h0, 24'h0, "R2 reset palette");
        drain();

        // Load a computed palette pattern.
        for (int i = 0; i < 256; i++)
            cycle(1'b0, 8'h0, 32'h0, 32'h0, 1'b1, 1'b1, i[7:0],
                  {i[7:0], 8'(i * 37 + 11), 8'(255 - i)}, "");

        // R4..R8: sweep all entries in each depth; upper control bytes carry 0x03.
        for (int f = 0; f < 4; f++) begin
            string tg;
            cfg_fmt = f[1:0];
            tg = (f == 0) ? "R5 pack8 R4" : (f == 1) ? "R6 pack15 R4" :
                 (f == 2) ? "R7 pack16 R4" : "R8 pack32 R4";
            for (int i = 0; i < 256; i++)
                cycle(1'b1, i[7:0], 32'hA5A5A5A5,
                      {8'h03, 8'h03, 8'h03, (i == 3) ? 8'h04 : i[7:0]},
                      1'b1, 1'b0, 8'h0, 24'h0, tg);
            drain();
        end

        // R3: direct colour in 32-bit depth.
        cfg_fmt = 2'd3;
        for (int i = 0; i < 64; i++)
            cycle(1'b1, i[7:0], {8'(i * 5), 8'(i * 11 + 1), 8'(255 - i * 3), 8'(i * 7)},
                  32'h00000003 | (32'(i) << 8), 1'b1, 1'b0, 8'h0, 24'h0, "R3 direct");
        drain();

        // R9: code 0x03 ignored outside 32-bit depth.
        for (int f = 0; f < 3; f++) begin
            cfg_fmt = f[1:0];
            for (int i = 0; i < 32; i++)
                cycle(1'b1, 8'(i * 8 + 1), 32'h12345678, 32'h00000003, 1'b1, 1'b0, 8'h0, 24'h0,
                      "R9 direct disabled");
            drain();
        end

        // R11: irregular stalls with mixed direct and palette pixels.
        cfg_fmt = 2'd3;
        lat_on = 1'b0;
        for (int i = 0; i < 300; i++)
            cycle((i % 5) != 2, 8'(i * 13), {8'(i), 8'(i + 1), 8'(i + 2), 8'(i + 3)},
                  (i % 2 == 0) ? 32'h00000003 : 32'h00000001, (i % 3) != 0,
                  1'b0, 8'h0, 24'h0, "R11 stream");
        drain();
        lat_on = 1'b1;

        // R12: write and accept at one edge sees old entry; next pixel sees new.
        cycle(1'b1, 8'd5, 32'h0, 32'h0, 1'b1, 1'b1, 8'd5, 24'h13579B, "R12 old entry");
        cycle(1'b1, 8'd5, 32'h0, 32'h0, 1'b1, 1'b0, 8'h0, 24'h0, "R12 new entry");
        drain();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule